// File: doc/BRIEF.md
# Switch Output Pin Mapper

This block holds two 4-bit switch-state registers and drives eight switch-control pins from them. One register is the committed group: low/high band, polarisation, satellite position and switch option. The other is the uncommitted group of four general switches. Neighbouring logic, such as a command decoder, writes into either register through a shared masked write port. A static mode input selects how the eight pins present that state:

- each bit on its own pin;
- a one-hot decode of three committed lines onto all eight pins;
- a one-hot decode of two committed lines onto the lower four pins;
- the committed bits on the lower half and their inverse on the upper half.

Every pin comes from a single output register. A change to a register or to the mode therefore reaches all eight pins on the same clock edge, and a decoded output never passes through a state with two or zero active lines.

Top module: `sw_pin_mapper`

## Requirements
- R1: In single mode (`mode`=2'b00), `op_pins[0..3]` carry committed bits 0..3, which are in order low/high band, polarisation, satellite position and switch option. `op_pins[4..7]` carry uncommitted bits 0..3.
- R2: A write with `cmt_wr_en` or `unc_wr_en` high loads `wr_data` only into the bits of the selected register whose `wr_mask` bit is 1. Bits whose mask bit is 0 keep their value, and a cycle with no enable changes nothing.
- R3: In 8-way decode mode (`mode`=2'b01), the index {switch option, satellite position, band} selects `op_pins` = 1 << index. The polarisation bit and the uncommitted register have no effect.
- R4: In 4-way decode mode (`mode`=2'b10), the index {switch option, satellite position} selects `op_pins[3:0]` = 1 << index, and `op_pins[7:4]` is 0. The band bit, the polarisation bit and the uncommitted register have no effect.
- R5: In complementary mode (`mode`=2'b11), `op_pins[3:0]` equals the committed register and `op_pins[7:4]` equals its bitwise inverse. The uncommitted register has no effect.
- R6: A write taken at clock edge k appears on the pins at edge k+1, on all pins together, and the pins hold their previous value between the two edges.
- R7: While a decode mode is held, exactly one pin is high in every cycle, including the cycle in which several index bits change at once.
- R8: A clock edge with `rst_n` low clears both registers and loads the pins with the zero-state pattern of the current mode: 8'h00 (single), 8'h01 (8-way), 8'h01 (4-way) or 8'hF0 (complementary).
- R9: A change of `mode` keeps the register contents and takes effect on the pins at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Output mode: 00 single, 01 8-way decode, 10 4-way decode, 11 complementary |
| cmt_wr_en | input | 1 | Write strobe for the committed register |
| unc_wr_en | input | 1 | Write strobe for the uncommitted register |
| wr_mask | input | 4 | Per-bit write enable |
| wr_data | input | 4 | Write data |
| op_pins | output | 8 | Switch-control pins, bit 0 is the first pin |

## Verification
The hardest case to reach from the ports is a decoded output changing while every index bit changes at once. A defect there would show an extra or missing active line for only one cycle. The stimulus sets the index to 0, then writes all three index bits in a single masked write. The pins are compared in the cycle right after the write edge, where the old one-hot value must still hold, and again one cycle later. Bits that should be ignored are toggled while the pins are checked to stay unchanged, and masked-off bits are revealed by switching to single mode.

// File: rtl/sw_pin_mapper_pkg.sv
// Package: shared types and bit positions for the switch pin mapper.
// Assumes committed group width 4 and uncommitted width 4 by default.
package sw_pin_mapper_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_DEC8   = 2'b01,
        MODE_DEC4   = 2'b10,
        MODE_COMPL  = 2'b11
    } outmode_e;

    // Bit positions inside the committed register; decode order depends on them.
    localparam int unsigned BIT_BAND = 0;
    localparam int unsigned BIT_POL  = 1;
    localparam int unsigned BIT_POS  = 2;
    localparam int unsigned BIT_OPT  = 3;

endpackage

// File: rtl/sw_state_bank.sv
// Module: sw_state_bank
// Holds one switch-state register with a masked write port.
// Assumes writes are already qualified by the owning command logic.
module sw_state_bank #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_mask,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] state_q
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            // Per-bit storage: load on enabled and unmasked write, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    state_q[gi] <= 1'b0;
                else if (wr_en && wr_mask[gi])
                    state_q[gi] <= wr_data[gi];
            end
        end
    endgenerate

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((state_q & ~$past(wr_mask)) == ($past(state_q) & ~$past(wr_mask)))) // R2
        else $error("masked-off bit changed");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(state_q)) // R2
        else $error("state changed without write");

endmodule

// File: rtl/onehot_dec.sv
// Module: onehot_dec
// Binary index to one-hot vector; output bit i is high when index equals i.
// Assumes the output width is 2**IDX_W.
module onehot_dec #(
    parameter int unsigned IDX_W = 3,
    localparam int unsigned OUT_W = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] onehot
);

    genvar gi;
    generate
        for (gi = 0; gi < OUT_W; gi++) begin : g_line
            // One compare per output line.
            assign onehot[gi] = (idx == IDX_W'(gi));
        end
    endgenerate

endmodule

// File: rtl/pin_map_logic.sv
// Module: pin_map_logic
// Combinational pin pattern for each output mode from the two state registers.
// Assumes a committed width of 4 (band, polarisation, position, option).
module pin_map_logic
    import sw_pin_mapper_pkg::*;
#(
    parameter int unsigned CMT_W = 4,
    parameter int unsigned UNC_W = 4,
    localparam int unsigned PIN_W = CMT_W + UNC_W
) (
    input  outmode_e         mode,
    input  logic [CMT_W-1:0] cmt,
    input  logic [UNC_W-1:0] unc,
    output logic [PIN_W-1:0] pins
);

    localparam int unsigned HALF = CMT_W;

    logic [2:0] idx8;
    logic [1:0] idx4;
    logic [7:0] dec8;
    logic [3:0] dec4;

    // Index assembly from the selected committed lines.
    always_comb begin
        idx8 = {cmt[BIT_OPT], cmt[BIT_POS], cmt[BIT_BAND]};
        idx4 = {cmt[BIT_OPT], cmt[BIT_POS]};
    end

    onehot_dec #(.IDX_W(3)) u_dec8 (.idx(idx8), .onehot(dec8));
    onehot_dec #(.IDX_W(2)) u_dec4 (.idx(idx4), .onehot(dec4));

    // Mode select of the pin pattern.
    always_comb begin
        pins = '0;
        unique case (mode)
            MODE_SINGLE: pins = {unc, cmt};
            MODE_DEC8:   pins = PIN_W'(dec8);
            MODE_DEC4:   pins = PIN_W'(dec4);
            MODE_COMPL:  pins = {~cmt[HALF-1:0], cmt};
            default:     pins = '0;
        endcase
    end

endmodule

// File: rtl/sw_pin_mapper.sv
// Module: sw_pin_mapper (top)
// Two switch-state registers and one output register that drives all pins.
// Assumes mode is static during normal use; a change applies on the next edge.
module sw_pin_mapper
    import sw_pin_mapper_pkg::*;
#(
    parameter int unsigned CMT_W = 4,
    parameter int unsigned UNC_W = 4,
    localparam int unsigned PIN_W = CMT_W + UNC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             cmt_wr_en,
    input  logic             unc_wr_en,
    input  logic [3:0]       wr_mask,
    input  logic [3:0]       wr_data,
    output logic [7:0]       op_pins
);

    outmode_e         mode_e;
    logic [CMT_W-1:0] cmt_q;
    logic [UNC_W-1:0] unc_q;
    logic [PIN_W-1:0] pins_d;
    logic [PIN_W-1:0] zero_pattern;

    // Mode input cast to the enumerated type.
    always_comb mode_e = outmode_e'(mode);

    sw_state_bank #(.WIDTH(CMT_W)) u_cmt_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cmt_wr_en),
        .wr_mask(wr_mask[CMT_W-1:0]), .wr_data(wr_data[CMT_W-1:0]), .state_q(cmt_q)
    );

    sw_state_bank #(.WIDTH(UNC_W)) u_unc_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(unc_wr_en),
        .wr_mask(wr_mask[UNC_W-1:0]), .wr_data(wr_data[UNC_W-1:0]), .state_q(unc_q)
    );

    pin_map_logic #(.CMT_W(CMT_W), .UNC_W(UNC_W)) u_map (
        .mode(mode_e), .cmt(cmt_q), .unc(unc_q), .pins(pins_d)
    );

    pin_map_logic #(.CMT_W(CMT_W), .UNC_W(UNC_W)) u_map_zero (
        .mode(mode_e), .cmt('0), .unc('0), .pins(zero_pattern)
    );

    // Single output register: all pins move on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_pins <= zero_pattern;
        else
            op_pins <= pins_d;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cmt_q == '0 && unc_q == '0)) // R8
        else $error("registers not cleared by reset");

    AST_SINGLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_SINGLE && $past(mode_e) == MODE_SINGLE)
            |-> op_pins == $past({unc_q, cmt_q})) // R1
        else $error("single mode pins do not follow registers");

    AST_DEC_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_e == MODE_DEC8 || mode_e == MODE_DEC4) && $past(mode_e) == mode_e)
            |-> $countones(op_pins) == 1) // R7
        else $error("decode mode pins not one-hot");

    AST_DEC4_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_DEC4 && $past(mode_e) == MODE_DEC4) |-> op_pins[7:4] == 4'h0) // R4
        else $error("upper pins active in 4-way decode");

    AST_COMPL_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_COMPL && $past(mode_e) == MODE_COMPL)
            |-> op_pins[7:4] == ~op_pins[3:0]) // R5
        else $error("complementary halves mismatch");

endmodule

// File: tb/sw_pin_mapper_bench.sv
// Scoreboard bench: driver tasks push expected pin values, monitor pops and compares.
module sw_pin_mapper_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cmt_wr_en = 1'b0;
    logic       unc_wr_en = 1'b0;
    logic [3:0] wr_mask = 4'h0;
    logic [3:0] wr_data = 4'h0;
    logic [7:0] op_pins;

    int n_vec = 0;
    int n_bad = 0;
    logic [3:0] cmt_m = 4'h0;
    logic [3:0] unc_m = 4'h0;

    typedef struct { logic [7:0] val; string req; } item_t;
    item_t exp_q[$];
    event  chk_ev;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    sw_pin_mapper u_sw_pin_mapper (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmt_wr_en(cmt_wr_en),
        .unc_wr_en(unc_wr_en), .wr_mask(wr_mask), .wr_data(wr_data), .op_pins(op_pins)
    );

    // Reference pattern built from the requirement text.
    function automatic logic [7:0] expect_pins(logic [1:0] m, logic [3:0] c, logic [3:0] u);
        logic [2:0] i8;
        logic [1:0] i4;
        i8 = {c[3], c[2], c[0]};
        i4 = {c[3], c[2]};
        case (m)
            2'b00:   return {u, c};
            2'b01:   return 8'h01 << i8;
            2'b10:   return {4'h0, 4'h1 << i4};
            default: return {~c, c};
        endcase
    endfunction

    task automatic push(string req);
        item_t it;
        it.val = expect_pins(mode, cmt_m, unc_m);
        it.req = req;
        exp_q.push_back(it);
        ->chk_ev;
    endtask

    // Monitor: pops each expected item and compares it with the pins.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_vec++;
                if (op_pins !== it.val) begin
                    n_bad++;
                    $display("FAIL %s: op_pins=%h expected=%h", it.req, op_pins, it.val);
                end
            end
        end
    end

    // Masked write; checks old value after the write edge and new value one edge later.
    task automatic wr(bit to_cmt, logic [3:0] msk, logic [3:0] dat, string req);
        @(negedge clk);
        cmt_wr_en = to_cmt;
        unc_wr_en = !to_cmt;
        wr_mask = msk;
        wr_data = dat;
        @(negedge clk);
        cmt_wr_en = 1'b0;
        unc_wr_en = 1'b0;
        push({req, " R6 hold"});
        if (to_cmt) cmt_m = (cmt_m & ~msk) | (dat & msk);
        else        unc_m = (unc_m & ~msk) | (dat & msk);
        @(negedge clk);
        push(req);
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
        push("R9 mode change");
    endtask

    task automatic do_reset(logic [1:0] m);
        @(negedge clk);
        mode = m;
        rst_n = 1'b0;
        cmt_m = 4'h0;
        unc_m = 4'h0;
        @(negedge clk);
        @(negedge clk);
        push("R8 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        push("R8 after reset");
    endtask

    initial begin
        for (int m = 0; m < 4; m++) do_reset(2'(m));

        // R1 single mode, both groups and pin order
        do_reset(2'b00);
        wr(1'b1, 4'hF, 4'h5, "R1 committed bits");
        wr(1'b0, 4'hF, 4'hA, "R1 uncommitted bits");
        wr(1'b1, 4'h2, 4'hF, "R2 single-bit set");
        wr(1'b1, 4'h0, 4'h0, "R2 empty mask");
        wr(1'b0, 4'h9, 4'h6, "R2 partial mask");

        // R9 mode change keeps the registers
        set_mode(2'b11);
        set_mode(2'b00);

        // R3 8-way decode over all indices
        do_reset(2'b01);
        for (int i = 0; i < 8; i++) begin
            logic [3:0] d;
            d = {i[2], i[1], 1'b0, i[0]};
            wr(1'b1, 4'hD, d, "R3 decode index");
        end
        wr(1'b1, 4'hD, 4'h0, "R7 back to index 0");
        wr(1'b1, 4'hD, 4'hD, "R7 all index bits change");
        wr(1'b1, 4'h2, 4'h2, "R3 polarisation ignored");
        wr(1'b0, 4'hF, 4'hF, "R3 uncommitted ignored");

        // R4 4-way decode
        set_mode(2'b10);
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, 4'hC, {2'(i), 2'b00}, "R4 decode index");
        end
        wr(1'b1, 4'h3, 4'h3, "R4 band and polarisation ignored");
        wr(1'b0, 4'hF, 4'h0, "R4 uncommitted ignored");
        wr(1'b1, 4'hC, 4'h0, "R7 two index bits change");

        // R5 complementary
        set_mode(2'b11);
        wr(1'b1, 4'hF, 4'h6, "R5 inverse halves");
        wr(1'b1, 4'hF, 4'h9, "R5 inverse halves second pattern");
        wr(1'b0, 4'hF, 4'h3, "R5 uncommitted ignored");

        // R2 confirm masked-off bits by viewing them directly
        set_mode(2'b00);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog ends a hung run as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule